// File: doc/BRIEF.md
# Serial Boot Stream Loader

This block turns a byte stream from a serial receiver into writes on a 16-bit program memory port. A boot sequence pulses `start_i` and the block then parses a fixed header. In signature mode the header opens with a four-byte signature. Every loading mode then carries a 32-bit word count and a 32-bit load address. All of these fields are sent least significant byte first.

After the header the block takes bytes in pairs, low byte first. It joins each pair into one 16-bit word and writes that word to successive program addresses, starting at the load address. When the counted number of words has been written, it raises `done_o` and keeps the load address on `start_addr_o` so that the boot sequencer can jump there.

The count and the address are taken as received, with no range check. A wrong signature byte raises `error_o`, stops parsing and blocks every memory write until the next start.

Top module: `boot_stream_loader`

## Requirements
- R1: After reset, `done_o`, `error_o` and `mem_we_o` are low. Bytes offered before the first `start_i` pulse cause no write and no flag.
- R2: With `sig_mode_i` high at start, the first four accepted bytes must be 0x43, 0x4F, 0x4F, 0x54 in that order. Only then does the count field begin.
- R3: A signature byte that differs from the expected one sets `error_o` in the cycle after that byte is taken. The parser returns to idle. No memory write happens until the next start, and `error_o` holds until then.
- R4: With `sig_mode_i` low at start, the first accepted byte is already byte 0 of the word count.
- R5: The count and the load address are each four bytes, least significant byte first. `start_addr_o` shows the full 32-bit load address while `done_o` is high.
- R6: Each program word is two bytes, low byte first, and fills `mem_wdata_o` bits 7:0 and 15:8 in that order. `mem_we_o` is high for exactly one cycle, in the cycle after the second byte of the pair is taken.
- R7: The first write goes to the low `ADDR_W` bits of the load address. Each later write goes to the previous address plus one.
- R8: `done_o` rises in the same cycle as the write of the last counted word. It stays high with `start_addr_o` unchanged until the next start, and bytes offered meanwhile cause no write.
- R9: A word count of zero raises `done_o` in the cycle after the last address byte, with no write.
- R10: A `start_i` pulse at any point restarts parsing at the first header field and clears `done_o` and `error_o` in the next cycle. A byte offered in the same cycle as `start_i` is dropped.
- R11: Idle cycles between bytes (`byte_valid_i` low) change neither the parse nor the data written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts or restarts a load |
| sig_mode_i | input | 1 | Sampled at start: 1 means the stream opens with the signature |
| byte_valid_i | input | 1 | `byte_data_i` carries a byte this cycle |
| byte_data_i | input | 8 | Received byte |
| mem_we_o | output | 1 | Program memory write strobe |
| mem_addr_o | output | ADDR_W | Program memory word address |
| mem_wdata_o | output | 16 | Program word to write |
| done_o | output | 1 | Load finished |
| error_o | output | 1 | Signature mismatch |
| start_addr_o | output | 32 | Load address to execute from |

## Verification
The bench targets the byte-order corners. It uses non-symmetric count, address and word values, so a loader that swapped bytes would write to the wrong addresses or write swapped data. It uses a wrong third signature byte, which a loader that only checks the first byte, or that keeps running after a mismatch, would miss by still writing memory. It also covers a zero count, which a loader that decrements before testing would turn into about four billion writes, and an abort in mid-header followed by a fresh start, which leaves a stale byte index behind if the restart does not clear it. It spaces bytes with idle gaps and sends bytes after `done_o`, which catches a loader that treats a dropped valid as data or that accepts trailing bytes.

// File: rtl/boot_ldr_pkg.sv
// Shared types and constants for the serial boot stream loader.
package boot_ldr_pkg;
    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 32;
    localparam int WORD_W  = 16;
    localparam int FIELD_BYTES = FIELD_W / BYTE_W;
    localparam int IDX_W   = $clog2(FIELD_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIG,
        ST_COUNT,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } ldr_state_e;

    // Expected signature byte for a given position in the prefix.
    function automatic logic [BYTE_W-1:0] sig_byte(input logic [IDX_W-1:0] idx);
        case (idx)
            2'd0:    sig_byte = 8'h43;
            2'd1:    sig_byte = 8'h4F;
            2'd2:    sig_byte = 8'h4F;
            default: sig_byte = 8'h54;
        endcase
    endfunction
endpackage

// File: rtl/boot_ldr_accum.sv
// Byte accumulator: shifts each accepted byte in at the top, so after N bytes
// sent least significant first the value sits right-aligned in the upper N bytes.
// Assumes the sequencer clears it at every start.
module boot_ldr_accum #(
    parameter int ACC_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [ACC_W-1:0]  acc_next_o
);
    logic [ACC_W-1:0] acc_q;

    // Value the register takes if the current byte is accepted.
    assign acc_next_o = {byte_i, acc_q[ACC_W-1:BYTE_W]};

    // Hold or shift the accumulated bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q <= '0;
        end else if (shift_i) begin
            acc_q <= acc_next_o;
        end
    end
endmodule

// File: rtl/boot_ldr_sig_match.sv
// Signature comparator: flags whether the incoming byte equals the expected
// prefix byte at the given position. Purely combinational.
module boot_ldr_sig_match
    import boot_ldr_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              match_o
);
    // Compare against the computed prefix byte.
    always_comb begin
        match_o = (byte_i == sig_byte(idx_i));
    end
endmodule

// File: rtl/boot_ldr_seq.sv
// Parse sequencer: walks signature, count, address and data phases, counts
// bytes within a field, and issues one memory write per received byte pair.
// Assumes acc_next_i carries the accumulator value including the current byte.
module boot_ldr_seq
    import boot_ldr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               sig_mode_i,
    input  logic               byte_valid_i,
    input  logic [FIELD_W-1:0] acc_next_i,
    input  logic               sig_match_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               take_o,
    output logic               done_o,
    output logic               error_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    output logic [FIELD_W-1:0] start_addr_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIELD_BYTES - 1);

    ldr_state_e         state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [FIELD_W-1:0] remain_q;
    logic [ADDR_W-1:0]  next_addr_q;
    logic               receiving;

    // A byte is consumed only in a receiving phase and never alongside a start.
    always_comb begin
        receiving = (state_q == ST_SIG) || (state_q == ST_COUNT) ||
                    (state_q == ST_ADDR) || (state_q == ST_DATA);
        take_o    = byte_valid_i && receiving && !start_i;
    end

    assign idx_o  = idx_q;
    assign done_o = (state_q == ST_DONE);

    // Phase sequencing, field capture and write generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            idx_q        <= '0;
            remain_q     <= '0;
            next_addr_q  <= '0;
            start_addr_o <= '0;
            error_o      <= 1'b0;
            mem_we_o     <= 1'b0;
            mem_addr_o   <= '0;
            mem_wdata_o  <= '0;
        end else begin
            mem_we_o <= 1'b0;
            if (start_i) begin
                state_q <= sig_mode_i ? ST_SIG : ST_COUNT;
                idx_q   <= '0;
                error_o <= 1'b0;
            end else if (take_o) begin
                idx_q <= idx_q + 1'b1;
                case (state_q)
                    ST_SIG: begin
                        if (!sig_match_i) begin
                            error_o <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (idx_q == LAST_IDX) begin
                            state_q <= ST_COUNT;
                        end
                    end
                    ST_COUNT: begin
                        if (idx_q == LAST_IDX) begin
                            remain_q <= acc_next_i;
                            state_q  <= ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        if (idx_q == LAST_IDX) begin
                            start_addr_o <= acc_next_i;
                            next_addr_q  <= acc_next_i[ADDR_W-1:0];
                            state_q      <= (remain_q == '0) ? ST_DONE : ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (idx_q[0]) begin
                            mem_we_o    <= 1'b1;
                            mem_wdata_o <= acc_next_i[FIELD_W-1:FIELD_W-WORD_W];
                            mem_addr_o  <= next_addr_q;
                            next_addr_q <= next_addr_q + 1'b1;
                            remain_q    <= remain_q - 1'b1;
                            if (remain_q == FIELD_W'(1)) begin
                                state_q <= ST_DONE;
                            end
                        end
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/boot_stream_loader.sv
// Serial boot stream loader top: joins the byte accumulator, the signature
// comparator and the parse sequencer. Assumes one byte per valid cycle and
// that the memory accepts a write every cycle the strobe is high.
module boot_stream_loader
    import boot_ldr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sig_mode_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_data_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    output logic              done_o,
    output logic              error_o,
    output logic [31:0]       start_addr_o
);
    logic [FIELD_W-1:0] acc_next;
    logic [IDX_W-1:0]   idx;
    logic               take;
    logic               sig_match;

    boot_ldr_accum #(.ACC_W(FIELD_W), .BYTE_W(BYTE_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_i),
        .shift_i    (take),
        .byte_i     (byte_data_i),
        .acc_next_o (acc_next)
    );

    boot_ldr_sig_match u_sig (
        .idx_i   (idx),
        .byte_i  (byte_data_i),
        .match_o (sig_match)
    );

    boot_ldr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .sig_mode_i   (sig_mode_i),
        .byte_valid_i (byte_valid_i),
        .acc_next_i   (acc_next),
        .sig_match_i  (sig_match),
        .idx_o        (idx),
        .take_o       (take),
        .done_o       (done_o),
        .error_o      (error_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .start_addr_o (start_addr_o)
    );
endmodule

// File: rtl/boot_stream_loader_chk.sv
// Property checker for the boot stream loader, attached by bind.
// Tracks the last write address itself to check address stepping.
module boot_stream_loader_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              done_o,
    input logic              error_o,
    input logic [31:0]       start_addr_o
);
    logic              seen_wr_q;
    logic [ADDR_W-1:0] last_addr_q;

    // Remember the previous write address within one load.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            seen_wr_q   <= 1'b0;
            last_addr_q <= '0;
        end else if (mem_we_o) begin
            seen_wr_q   <= 1'b1;
            last_addr_q <= mem_addr_o;
        end
    end

    a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && seen_wr_q) |-> (mem_addr_o == last_addr_q + 1'b1));

    a_r3_no_write_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> !mem_we_o);

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(error_o && done_o));

    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r8_start_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(start_addr_o));

    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !error_o));
endmodule

bind boot_stream_loader boot_stream_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .done_o       (done_o),
    .error_o      (error_o),
    .start_addr_o (start_addr_o)
);

// File: tb/boot_stream_loader_tb.sv
// Directed bench for the boot stream loader: one task per scenario.
module boot_stream_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              sig_mode_i = 1'b0;
    logic              byte_valid_i = 1'b0;
    logic [7:0]        byte_data_i = '0;
    logic              mem_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [15:0]       mem_wdata_o;
    logic              done_o;
    logic              error_o;
    logic [31:0]       start_addr_o;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;

    logic [ADDR_W-1:0] wr_addr [0:63];
    logic [15:0]       wr_data [0:63];
    int                wr_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_stream_loader #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sig_mode_i(sig_mode_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .done_o(done_o), .error_o(error_o), .start_addr_o(start_addr_o)
    );

    // Log every write cycle, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            if (wr_n < 64) begin
                wr_addr[wr_n] = mem_addr_o;
                wr_data[wr_n] = mem_wdata_o;
            end
            wr_n = wr_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        @(negedge clk);
        byte_valid_i = 1'b1;
        byte_data_i  = b;
        @(negedge clk);
        byte_valid_i = 1'b0;
        byte_data_i  = 8'hxx;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send32(input logic [31:0] v, input int gap);
        for (int i = 0; i < 4; i++) send_byte(v[8*i +: 8], gap);
    endtask

    task automatic send_word(input logic [15:0] w, input int gap);
        send_byte(w[7:0], gap);
        send_byte(w[15:8], gap);
    endtask

    task automatic send_sig(input int gap);
        send_byte(8'h43, gap);
        send_byte(8'h4F, gap);
        send_byte(8'h4F, gap);
        send_byte(8'h54, gap);
    endtask

    task automatic pulse_start(input bit mode);
        @(negedge clk);
        sig_mode_i = mode;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        wr_n       = 0;
    endtask

    // R1: reset state and bytes ignored before any start.
    task automatic t_reset;
        check(done_o == 1'b0, "R1 done after reset", 32'(done_o), 0);
        check(error_o == 1'b0, "R1 error after reset", 32'(error_o), 0);
        check(mem_we_o == 1'b0, "R1 we after reset", 32'(mem_we_o), 0);
        wr_n = 0;
        send32(32'h0000_0001, 0);
        send32(32'h0000_0010, 0);
        send_word(16'hAAAA, 0);
        idle(2);
        check(wr_n == 0, "R1 no write before start", 32'(wr_n), 0);
        check(done_o == 1'b0, "R1 no done before start", 32'(done_o), 0);
    endtask

    // R2 R5 R6 R7 R8: signature mode, three words, trailing bytes ignored.
    task automatic t_sig_ok;
        logic [15:0] words [3];
        words[0] = 16'h1234; words[1] = 16'hBEEF; words[2] = 16'h00FF;
        pulse_start(1'b1);
        send_sig(0);
        send32(32'd3, 0);
        send32(32'h0000_0120, 0);
        send_word(words[0], 0);
        send_word(words[1], 0);
        check(done_o == 1'b0, "R8 not done before last word", 32'(done_o), 0);
        send_word(words[2], 0);
        check(done_o == 1'b1, "R8 done with last write", 32'(done_o), 1);
        check(mem_we_o == 1'b1, "R8 last write same cycle as done", 32'(mem_we_o), 1);
        idle(1);
        check(wr_n == 3, "R6 write count", 32'(wr_n), 3);
        for (int i = 0; i < 3; i++) begin
            check(wr_addr[i] == ADDR_W'(16'h0120 + i), "R7 write address",
                  32'(wr_addr[i]), 32'h120 + i);
            check(wr_data[i] == words[i], "R6 word data low byte first",
                  32'(wr_data[i]), 32'(words[i]));
        end
        check(start_addr_o == 32'h0000_0120, "R5 start address",
              start_addr_o, 32'h120);
        check(error_o == 1'b0, "R2 no error on good signature", 32'(error_o), 0);
        send_word(16'h5555, 0);
        idle(2);
        check(wr_n == 3, "R8 bytes after done ignored", 32'(wr_n), 3);
        check(done_o == 1'b1, "R8 done holds", 32'(done_o), 1);
    endtask

    // R3: bad third signature byte.
    task automatic t_sig_bad;
        pulse_start(1'b1);
        send_byte(8'h43, 0);
        send_byte(8'h4F, 0);
        check(error_o == 1'b0, "R3 no error on matching bytes", 32'(error_o), 0);
        send_byte(8'h58, 0);
        check(error_o == 1'b1, "R3 error on mismatch", 32'(error_o), 1);
        send_byte(8'h54, 0);
        send32(32'd1, 0);
        send32(32'h0000_0040, 0);
        send_word(16'hCAFE, 0);
        idle(2);
        check(wr_n == 0, "R3 no write after mismatch", 32'(wr_n), 0);
        check(error_o == 1'b1, "R3 error holds", 32'(error_o), 1);
        check(done_o == 1'b0, "R3 no done after mismatch", 32'(done_o), 0);
    endtask

    // R4 R5 R7 R11: no signature, wide address, idle gaps between bytes.
    task automatic t_plain_gaps;
        pulse_start(1'b0);
        check(error_o == 1'b0, "R10 start clears error", 32'(error_o), 0);
        send32(32'd2, 2);
        send32(32'h1234_5678, 3);
        send_word(16'hA55A, 1);
        send_word(16'h0F1E, 4);
        idle(1);
        check(done_o == 1'b1, "R4 done without signature", 32'(done_o), 1);
        check(wr_n == 2, "R11 write count with gaps", 32'(wr_n), 2);
        check(wr_addr[0] == 16'h5678, "R7 first address from load address",
              32'(wr_addr[0]), 32'h5678);
        check(wr_addr[1] == 16'h5679, "R7 address increments",
              32'(wr_addr[1]), 32'h5679);
        check(wr_data[0] == 16'hA55A, "R11 data with gaps", 32'(wr_data[0]), 32'hA55A);
        check(wr_data[1] == 16'h0F1E, "R11 data with gaps", 32'(wr_data[1]), 32'h0F1E);
        check(start_addr_o == 32'h1234_5678, "R5 full start address",
              start_addr_o, 32'h1234_5678);
    endtask

    // R9: zero count.
    task automatic t_zero;
        pulse_start(1'b0);
        check(done_o == 1'b0, "R10 start clears done", 32'(done_o), 0);
        send32(32'd0, 0);
        send_byte(8'h00, 0);
        send_byte(8'h02, 0);
        send_byte(8'h00, 0);
        check(done_o == 1'b0, "R9 not done before last address byte", 32'(done_o), 0);
        send_byte(8'h00, 0);
        check(done_o == 1'b1, "R9 done after address", 32'(done_o), 1);
        send_word(16'h7777, 0);
        idle(2);
        check(wr_n == 0, "R9 no write on zero count", 32'(wr_n), 0);
        check(start_addr_o == 32'h0000_0200, "R9 start address", start_addr_o, 32'h200);
    endtask

    // R10: restart in mid-header, and a byte in the start cycle is dropped.
    task automatic t_restart;
        pulse_start(1'b1);
        send_sig(0);
        send_byte(8'h05, 0);
        send_byte(8'h00, 0);
        @(negedge clk);
        sig_mode_i   = 1'b1;
        start_i      = 1'b1;
        byte_valid_i = 1'b1;
        byte_data_i  = 8'h99;
        @(negedge clk);
        start_i      = 1'b0;
        byte_valid_i = 1'b0;
        wr_n         = 0;
        send_sig(0);
        send32(32'd1, 0);
        send32(32'h0000_0ABC, 0);
        send_word(16'h6789, 0);
        idle(1);
        check(error_o == 1'b0, "R10 restart parses signature again", 32'(error_o), 0);
        check(done_o == 1'b1, "R10 restarted load completes", 32'(done_o), 1);
        check(wr_n == 1, "R10 one write after restart", 32'(wr_n), 1);
        check(wr_addr[0] == 16'h0ABC, "R10 address after restart",
              32'(wr_addr[0]), 32'hABC);
        check(wr_data[0] == 16'h6789, "R10 data after restart",
              32'(wr_data[0]), 32'h6789);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sig_ok();
        t_sig_bad();
        t_plain_gaps();
        t_zero();
        t_restart();
        idle(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule